// File: doc/BRIEF.md
# Systolic Edit Distance Array

This block computes the unit-cost edit distance (insertions, deletions and substitutions each cost one) between a stored source sequence of 2-bit symbols and a stream of target sequences. It is a chain of N identical cells. Cell k holds source symbol k and a running column of the dynamic-programming matrix. Each target symbol travels through the chain as a token. The token carries the distance of the matrix cell to its left, so every cell advances one matrix row per token. When a target's closing token leaves the last cell, the distance for that target is presented on the output for one cycle with a done pulse.

Two streaming modes use the same cells. In the preloaded mode (mode = 0) the source is written first through the left-end source port. Targets then enter at the left end and stream through the array back to back, each ending with a last flag. Many targets can be in flight at once, so nearly every cell is busy. In the counter-flow mode (mode = 1) target symbols enter at the right end and move leftward through a return chain. At the same time the source symbols enter from the left. Once a target symbol reaches the left end it turns and crosses the cells. The source and target can therefore be fed in the same cycle from opposite ends.

Latency is fixed by the array length, not by the sequence lengths. Distances saturate at the largest value the distance width can hold.

Top module: `seqdist_array`

## Requirements
- R1: After reset, done is 0 and dist_out is 0. Before any source is loaded, the source is empty.
- R2: In mode 0, with a source loaded through src_valid/src_sym and closed by src_last, each target closed by tgt_last produces on dist_out the unit-cost edit distance between the source and that target. Symbols are compared only for equality of their 2-bit codes.
- R3: Targets presented with no idle cycle between them, the first symbol of one following the last symbol of the previous, each get their own correct distance, in the order the targets were sent.
- R4: In mode 0, done for a target is high in the cycle that follows exactly N rising edges after the edge that accepted that target's last symbol.
- R5: In mode 1, target symbols entered at the right end, together with a source fed from the left starting in the same cycle, produce the same distance as in mode 0. done follows exactly 2N edges after the edge that accepted the last target symbol.
- R6: Source symbols beyond the N-th are ignored. The distance is computed against the first N symbols.
- R7: With an empty source, the distance equals the target length.
- R8: The first source symbol written after a src_last starts a new source, and this new source replaces the previous one entirely, including its length.
- R9: A distance whose true value is at least 2^DIST_W - 1 is reported as 2^DIST_W - 1. Smaller distances are exact.
- R10: Between done pulses, done stays 0 and dist_out keeps the last reported distance.
- R11: Each active cell forwards a distance that differs by at most one from the distance it received. An inactive cell forwards the received distance unchanged.
- R12: There is exactly one done pulse per target. Every done pulse corresponds to an earlier accepted target symbol carrying tgt_last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = targets enter at the left end; 1 = targets enter at the right end and counter-flow |
| src_valid | input | 1 | Source symbol valid (left end) |
| src_sym | input | 2 | Source symbol code |
| src_last | input | 1 | Marks the final symbol of the source |
| tgt_valid | input | 1 | Target symbol valid |
| tgt_sym | input | 2 | Target symbol code |
| tgt_last | input | 1 | Marks the final symbol of a target |
| dist_out | output | DIST_W | Distance of the most recently finished target |
| done | output | 1 | One-cycle pulse when dist_out takes a new result |

## Verification
The assertions assume the following about the inputs:
- Every target has at least one symbol.
- mode changes only while no target is in flight.
- The source is not rewritten while target tokens are crossing the cells.
- In mode 1, a source of at most N symbols starts entering no later than its target.

Under these conditions each cell's column stays consistent, so every result can be bounded by the source and target lengths. The directed stimulus changes mode and reloads the source only after waiting for all pending results, and it starts each counter-flow source and target in the same cycle. A second, narrow instance reaches saturation with short targets.

// File: rtl/seqdist_pkg.sv
package seqdist_pkg;
   localparam int SYM_W = 2;
   typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/seqdist_src_store.sv
module seqdist_src_store
   import seqdist_pkg::*;
#(
   parameter int N = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_valid,
   input  sym_t                    wr_sym,
   input  logic                    wr_last,
   output logic [N-1:0][SYM_W-1:0] src_syms,
   output logic [N-1:0]            col_active
);
   localparam int LEN_W = $clog2(N + 1);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [N-1:0][SYM_W-1:0] syms_q;
   logic [LEN_W-1:0]        len_q;
   logic                    fresh_q;
   logic [IDX_W-1:0]        wr_idx;

   assign wr_idx = IDX_W'(len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         syms_q  <= '0;
         len_q   <= '0;
         fresh_q <= 1'b1;
      end else if (wr_valid) begin
         if (fresh_q) begin
            syms_q[0] <= wr_sym;
            len_q     <= LEN_W'(1);
         end else if (len_q < LEN_W'(N)) begin
            syms_q[wr_idx] <= wr_sym;
            len_q          <= len_q + LEN_W'(1);
         end
         fresh_q <= wr_last;
      end
   end

   assign src_syms = syms_q;

   for (genvar k = 0; k < N; k++) begin : g_act
      assign col_active[k] = (len_q > LEN_W'(k));
   end
endmodule

// File: rtl/seqdist_return_chain.sv
module seqdist_return_chain
   import seqdist_pkg::*;
#(
   parameter int N = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_last,
   input  sym_t in_sym,
   output logic out_valid,
   output logic out_last,
   output sym_t out_sym
);
   logic [N-1:0]            v_q;
   logic [N-1:0]            l_q;
   logic [N-1:0][SYM_W-1:0] s_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         l_q <= '0;
         s_q <= '0;
      end else begin
         for (int k = 0; k < N - 1; k++) begin
            v_q[k] <= v_q[k+1];
            l_q[k] <= l_q[k+1];
            s_q[k] <= s_q[k+1];
         end
         v_q[N-1] <= in_valid;
         l_q[N-1] <= in_last;
         s_q[N-1] <= in_sym;
      end
   end

   assign out_valid = v_q[0];
   assign out_last  = l_q[0];
   assign out_sym   = s_q[0];
endmodule

// File: rtl/seqdist_injector.sv
module seqdist_injector
   import seqdist_pkg::*;
#(
   parameter int DIST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_last,
   input  sym_t              in_sym,
   output logic              out_valid,
   output logic              out_first,
   output logic              out_last,
   output sym_t              out_sym,
   output logic [DIST_W-1:0] out_dist
);
   localparam logic [DIST_W-1:0] DMAX = '1;

   logic [DIST_W-1:0] row_q;
   logic              fresh_q;

   always_comb begin
      out_valid = in_valid;
      out_first = fresh_q;
      out_last  = in_last;
      out_sym   = in_sym;
      if (fresh_q)
         out_dist = DIST_W'(1);
      else if (row_q == DMAX)
         out_dist = DMAX;
      else
         out_dist = row_q + DIST_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q   <= '0;
         fresh_q <= 1'b1;
      end else if (in_valid) begin
         row_q   <= out_dist;
         fresh_q <= in_last;
      end
   end
endmodule

// File: rtl/seqdist_cell.sv
module seqdist_cell
   import seqdist_pkg::*;
#(
   parameter int COL    = 1,
   parameter int DIST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  sym_t              src_sym,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic              in_last,
   input  sym_t              in_sym,
   input  logic [DIST_W-1:0] in_dist,
   output logic              out_valid,
   output logic              out_first,
   output logic              out_last,
   output sym_t              out_sym,
   output logic [DIST_W-1:0] out_dist
);
   localparam logic [DIST_W-1:0] DMAX  = '1;
   localparam logic [DIST_W-1:0] UP0   = DIST_W'(COL);
   localparam logic [DIST_W-1:0] DIAG0 = DIST_W'(COL - 1);

   function automatic logic [DIST_W-1:0] sat_step(input logic [DIST_W-1:0] v, input logic inc);
      if (!inc || v == DMAX) return v;
      return v + DIST_W'(1);
   endfunction

   logic [DIST_W-1:0] up_q, diag_q;
   logic [DIST_W-1:0] up_e, diag_e;
   logic [DIST_W-1:0] via_left, via_up, via_diag, best;

   always_comb begin
      up_e     = in_first ? UP0 : up_q;
      diag_e   = in_first ? DIAG0 : diag_q;
      via_left = sat_step(in_dist, 1'b1);
      via_up   = sat_step(up_e, 1'b1);
      via_diag = sat_step(diag_e, in_sym != src_sym);
      best     = (via_left < via_up) ? via_left : via_up;
      if (via_diag < best) best = via_diag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q      <= '0;
         diag_q    <= '0;
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_sym   <= '0;
         out_dist  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_first <= in_first;
            out_last  <= in_last;
            out_sym   <= in_sym;
            out_dist  <= active ? best : in_dist;
            if (active) begin
               up_q   <= best;
               diag_q <= in_dist;
            end
         end
      end
   end
endmodule

// File: rtl/seqdist_array.sv
module seqdist_array
   import seqdist_pkg::*;
#(
   parameter int N        = 16,
   parameter int DIST_W   = 16,
   parameter bit BIDIR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              src_valid,
   input  logic [1:0]        src_sym,
   input  logic              src_last,
   input  logic              tgt_valid,
   input  logic [1:0]        tgt_sym,
   input  logic              tgt_last,
   output logic [DIST_W-1:0] dist_out,
   output logic              done
);
   if (N < 1 || DIST_W < 2 || DIST_W > 30 || (N + 1) >= (1 << DIST_W)) begin : g_bad_cfg
      $error("seqdist_array: N must be >= 1 and N+1 below the distance ceiling");
   end

   logic [N-1:0][SYM_W-1:0]  src_syms;
   logic [N-1:0]             col_active;
   logic                     ent_valid, ent_last;
   sym_t                     ent_sym;
   logic [N:0]               tok_valid, tok_first, tok_last;
   logic [N:0][SYM_W-1:0]    tok_sym;
   logic [N:0][DIST_W-1:0]   tok_dist;
   logic [DIST_W-1:0]        dist_q;
   logic                     done_q;

   seqdist_src_store #(.N(N)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(src_valid), .wr_sym(src_sym), .wr_last(src_last),
      .src_syms(src_syms), .col_active(col_active)
   );

   if (BIDIR_EN) begin : g_bidir
      logic rc_valid, rc_last;
      sym_t rc_sym;
      seqdist_return_chain #(.N(N)) u_chain (
         .clk(clk), .rst_n(rst_n),
         .in_valid(tgt_valid & mode), .in_last(tgt_last), .in_sym(tgt_sym),
         .out_valid(rc_valid), .out_last(rc_last), .out_sym(rc_sym)
      );
      assign ent_valid = mode ? rc_valid : tgt_valid;
      assign ent_last  = mode ? rc_last  : tgt_last;
      assign ent_sym   = mode ? rc_sym   : tgt_sym;
   end else begin : g_uni
      logic unused_mode;
      assign unused_mode = mode;
      assign ent_valid   = tgt_valid;
      assign ent_last    = tgt_last;
      assign ent_sym     = tgt_sym;
   end

   seqdist_injector #(.DIST_W(DIST_W)) u_inj (
      .clk(clk), .rst_n(rst_n),
      .in_valid(ent_valid), .in_last(ent_last), .in_sym(ent_sym),
      .out_valid(tok_valid[0]), .out_first(tok_first[0]), .out_last(tok_last[0]),
      .out_sym(tok_sym[0]), .out_dist(tok_dist[0])
   );

   for (genvar k = 0; k < N; k++) begin : g_cell
      seqdist_cell #(.COL(k + 1), .DIST_W(DIST_W)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .active(col_active[k]), .src_sym(src_syms[k]),
         .in_valid(tok_valid[k]), .in_first(tok_first[k]), .in_last(tok_last[k]),
         .in_sym(tok_sym[k]), .in_dist(tok_dist[k]),
         .out_valid(tok_valid[k+1]), .out_first(tok_first[k+1]), .out_last(tok_last[k+1]),
         .out_sym(tok_sym[k+1]), .out_dist(tok_dist[k+1])
      );
   end

   logic unused_tail;
   assign unused_tail = ^{tok_first[N], tok_sym[N]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         dist_q <= '0;
      end else begin
         done_q <= tok_valid[N] & tok_last[N];
         if (tok_valid[N] & tok_last[N]) dist_q <= tok_dist[N];
      end
   end

   assign done     = done_q;
   assign dist_out = dist_q;
endmodule

// File: rtl/seqdist_array_chk.sv
module seqdist_array_chk #(
   parameter int N      = 16,
   parameter int DIST_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tgt_valid,
   input logic                   tgt_last,
   input logic                   done,
   input logic [DIST_W-1:0]      dist_out,
   input logic [N:0]             tok_valid,
   input logic [N:0]             tok_last,
   input logic [N:0][DIST_W-1:0] tok_dist,
   input logic [N-1:0]           col_active
);
   localparam int MAXD = (1 << DIST_W) - 1;

   int pend_q;
   int run_q;
   int tlen_q;
   int src_len;
   int gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 0;
         run_q  <= 0;
         tlen_q <= 0;
      end else begin
         pend_q <= pend_q + ((tgt_valid && tgt_last) ? 1 : 0) - (done ? 1 : 0);
         if (tok_valid[N]) begin
            if (tok_last[N]) begin
               tlen_q <= run_q + 1;
               run_q  <= 0;
            end else begin
               run_q <= run_q + 1;
            end
         end
      end
   end

   always_comb begin
      src_len = $countones(col_active);
      gap     = (tlen_q > src_len) ? tlen_q - src_len : src_len - tlen_q;
      if (gap > MAXD) gap = MAXD;
   end

   for (genvar k = 0; k < N; k++) begin : g_step
      // R11: neighbouring matrix cells differ by at most one
      assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid[k+1] |-> ((int'(tok_dist[k+1]) <= int'($past(tok_dist[k])) + 1) &&
                             (int'($past(tok_dist[k])) <= int'(tok_dist[k+1]) + 1)));
   end

   assert_done_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pend_q > 0));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dist_out));

   assert_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(dist_out) <= ((tlen_q > src_len) ? tlen_q : src_len)));

   assert_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(dist_out) >= gap));
endmodule

bind seqdist_array seqdist_array_chk #(.N(N), .DIST_W(DIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_last(tgt_last),
   .done(done), .dist_out(dist_out), .tok_valid(tok_valid), .tok_last(tok_last),
   .tok_dist(tok_dist), .col_active(col_active)
);

// File: tb/seqdist_array_tb.sv
`timescale 1ns/1ps
module seqdist_array_tb;
   localparam int N  = 8;
   localparam int W  = 16;
   localparam int SN = 4;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          mode = 1'b0;
   logic          src_valid = 1'b0, src_last = 1'b0;
   logic [1:0]    src_sym = '0;
   logic          tgt_valid = 1'b0, tgt_last = 1'b0;
   logic [1:0]    tgt_sym = '0;
   logic [W-1:0]  dist_out;
   logic          done;

   logic          s_src_valid = 1'b0, s_src_last = 1'b0;
   logic [1:0]    s_src_sym = '0;
   logic          s_tgt_valid = 1'b0, s_tgt_last = 1'b0;
   logic [1:0]    s_tgt_sym = '0;
   logic [SW-1:0] s_dist;
   logic          s_done;

   seqdist_array #(.N(N), .DIST_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .src_valid(src_valid), .src_sym(src_sym), .src_last(src_last),
      .tgt_valid(tgt_valid), .tgt_sym(tgt_sym), .tgt_last(tgt_last),
      .dist_out(dist_out), .done(done)
   );

   seqdist_array #(.N(SN), .DIST_W(SW)) u_sat (
      .clk(clk), .rst_n(rst_n), .mode(1'b0),
      .src_valid(s_src_valid), .src_sym(s_src_sym), .src_last(s_src_last),
      .tgt_valid(s_tgt_valid), .tgt_sym(s_tgt_sym), .tgt_last(s_tgt_last),
      .dist_out(s_dist), .done(s_done)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   int res_val[256], res_cyc[256];
   int res_cnt = 0;
   int sat_val[64];
   int sat_cnt = 0;
   int sent_cnt = 0;
   int last_acc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && done && res_cnt < 256) begin
         res_val[res_cnt] = int'(dist_out);
         res_cyc[res_cnt] = cyc;
         res_cnt++;
      end
      if (rst_n && s_done && sat_cnt < 64) begin
         sat_val[sat_cnt] = int'(s_dist);
         sat_cnt++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [1:0] sym_of(input byte c);
      case (c)
         "A": return 2'd0;
         "C": return 2'd1;
         "G": return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic int ref_ed(input string s, input string t, input int cap, input int maxv);
      int prev[0:64];
      int cur[0:64];
      int m, n, c, d;
      m = (s.len() < cap) ? s.len() : cap;
      n = t.len();
      for (int j = 0; j <= m; j++) prev[j] = j;
      for (int i = 1; i <= n; i++) begin
         cur[0] = i;
         for (int j = 1; j <= m; j++) begin
            c = prev[j-1] + ((s[j-1] != t[i-1]) ? 1 : 0);
            if (prev[j] + 1 < c) c = prev[j] + 1;
            if (cur[j-1] + 1 < c) c = cur[j-1] + 1;
            cur[j] = c;
         end
         for (int j = 0; j <= m; j++) prev[j] = cur[j];
      end
      d = prev[m];
      return (d > maxv) ? maxv : d;
   endfunction

   task automatic load_src(input string s);
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         src_valid = 1'b1;
         src_sym   = sym_of(s[i]);
         src_last  = (i == s.len() - 1);
      end
      @(negedge clk);
      src_valid = 1'b0;
      src_last  = 1'b0;
   endtask

   task automatic drive_tgt(input string t);
      for (int i = 0; i < t.len(); i++) begin
         @(negedge clk);
         tgt_valid = 1'b1;
         tgt_sym   = sym_of(t[i]);
         tgt_last  = (i == t.len() - 1);
         if (i == t.len() - 1) begin
            last_acc = cyc + 1;
            sent_cnt++;
         end
      end
   endtask

   task automatic tgt_idle();
      @(negedge clk);
      tgt_valid = 1'b0;
      tgt_last  = 1'b0;
   endtask

   task automatic wait_res(input string req, input int want);
      int guard = 0;
      while (res_cnt < want && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      chk({req, " result arrived"}, (res_cnt >= want) ? 1 : 0, 1);
   endtask

   task automatic run_one(input string req, input string s, input string t, input int cap);
      int base = res_cnt;
      drive_tgt(t);
      tgt_idle();
      wait_res(req, base + 1);
      chk(req, res_val[base], ref_ed(s, t, cap, (1 << W) - 1));
   endtask

   task automatic t_reset_R1();
      chk("R1 done after reset", int'(done), 0);
      chk("R1 dist after reset", int'(dist_out), 0);
   endtask

   task automatic t_empty_R7();
      run_one("R7", "", "ACGGT", N);
      chk("R7 length", res_val[res_cnt-1], 5);
   endtask

   task automatic t_uni_R2();
      load_src("GATTACA");
      run_one("R2 a", "GATTACA", "GCATGCT", N);
      run_one("R2 b", "GATTACA", "GATTACA", N);
      run_one("R2 c", "GATTACA", "T", N);
      run_one("R2 d", "GATTACA", "ACGTACGTACAT", N);
   endtask

   task automatic t_latency_R4();
      int base = res_cnt;
      drive_tgt("A");
      tgt_idle();
      wait_res("R4", base + 1);
      chk("R4 latency", res_cyc[base] - last_acc, N);
   endtask

   task automatic t_b2b_R3();
      int base = res_cnt;
      drive_tgt("GATC");
      drive_tgt("GATTACA");
      drive_tgt("CC");
      drive_tgt("T");
      tgt_idle();
      wait_res("R3", base + 4);
      chk("R3 first",  res_val[base],   ref_ed("GATTACA", "GATC", N, 65535));
      chk("R3 second", res_val[base+1], 0);
      chk("R3 third",  res_val[base+2], ref_ed("GATTACA", "CC", N, 65535));
      chk("R3 fourth", res_val[base+3], ref_ed("GATTACA", "T", N, 65535));
   endtask

   task automatic t_hold_R10();
      int keep, bad_done, bad_dist;
      keep = int'(dist_out);
      bad_done = 0;
      bad_dist = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (done) bad_done++;
         if (int'(dist_out) != keep) bad_dist++;
      end
      chk("R10 done stays low", bad_done, 0);
      chk("R10 dist held", bad_dist, 0);
   endtask

   task automatic t_long_R6();
      load_src("ACGTACGTTT");
      run_one("R6", "ACGTACGTTT", "ACGTACGT", N);
      chk("R6 capped", res_val[res_cnt-1], 0);
   endtask

   task automatic t_reload_R8();
      load_src("TTTTTTT");
      load_src("GG");
      run_one("R8", "GG", "GG", N);
      chk("R8 replaced", res_val[res_cnt-1], 0);
   endtask

   task automatic t_bidir_R5();
      int base = res_cnt;
      mode = 1'b1;
      fork
         load_src("CATTAG");
         begin
            drive_tgt("CTTAGG");
            tgt_idle();
         end
      join
      wait_res("R5", base + 1);
      chk("R5 dist", res_val[base], ref_ed("CATTAG", "CTTAGG", N, 65535));
      chk("R5 latency", res_cyc[base] - last_acc, 2 * N);
      base = res_cnt;
      fork
         load_src("GGGACT");
         begin
            drive_tgt("GACTAAC");
            tgt_idle();
         end
      join
      wait_res("R5 second", base + 1);
      chk("R5 second dist", res_val[base], ref_ed("GGGACT", "GACTAAC", N, 65535));
      @(negedge clk);
      mode = 1'b0;
   endtask

   task automatic sat_tgt(input string t);
      for (int i = 0; i < t.len(); i++) begin
         @(negedge clk);
         s_tgt_valid = 1'b1;
         s_tgt_sym   = sym_of(t[i]);
         s_tgt_last  = (i == t.len() - 1);
      end
      @(negedge clk);
      s_tgt_valid = 1'b0;
      s_tgt_last  = 1'b0;
      repeat (3 * SN + 4) @(negedge clk);
   endtask

   task automatic t_sat_R9();
      sat_tgt("AAAAAAAAAAAAAAAAAAAA");
      chk("R9 empty src saturates", sat_val[0], 15);
      @(negedge clk);
      s_src_valid = 1'b1; s_src_sym = sym_of("A"); s_src_last = 1'b0;
      @(negedge clk);
      s_src_sym = sym_of("C"); s_src_last = 1'b1;
      @(negedge clk);
      s_src_valid = 1'b0; s_src_last = 1'b0;
      sat_tgt("GGGGGGGGGGGGGGGGGGGG");
      chk("R9 loaded src saturates", sat_val[1], ref_ed("AC", "GGGGGGGGGGGGGGGGGGGG", SN, 15));
      sat_tgt("ACGTA");
      chk("R9 below ceiling exact", sat_val[2], ref_ed("AC", "ACGTA", SN, 15));
      chk("R9 result count", sat_cnt, 3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_R1();
      t_empty_R7();
      t_uni_R2();
      t_latency_R4();
      t_b2b_R3();
      t_hold_R10();
      t_long_R6();
      t_reload_R8();
      t_bidir_R5();
      t_sat_R9();
      repeat (4 * N) @(negedge clk);
      chk("R12 one done per target", res_cnt, sent_cnt);
      summary();
      $finish;
   end
endmodule